// File: doc/BRIEF.md
# RAM Cell Access Decoder

This block sits between three processor bus masters and a bank of thirteen RAM cells. Each cycle it takes one address per master and resolves it to a one-hot cell select and a 14-bit offset inside the cell. It also checks the address against a fixed permission table for each master. Accesses that the table forbids, or that hit no cell, raise an error pulse for that master and select nothing. Every decode result is registered, so it appears one clock after the request.

The cells are 16 KiB windows, laid out one after another from a configurable region base. Cells 11, 12 and 13 are trace buffers owned by masters 0, 1 and 2. Master 0 is the system processor, master 1 is the radio-controller processor and master 2 is the application processor. The system processor can open every trace buffer. Each of the other two can open only its own. Cell 8 is the shared mailbox that all processors can reach. Cells 9 and 10 hold the radio processor's code and data and sit in a slower clock domain. A two-bit remap register lets software place cell 1 or cell 3 at absolute address zero.

Accesses that cross into the slow domain raise a bridge-path flag so that logic downstream can add wait states. This covers the system processor reaching cells 9 or 10, and the radio processor reaching cell 8. Arbitration between masters is outside this block.

Top module: `ram_cell_decoder`

## Requirements
- R1: While reset is high, the remap register returns to "no remap" and every select, offset, error and bridge output goes to zero.
- R2: A valid request whose upper bits (above bit 17) equal those of the region base, and whose bits 17:14 hold a value v from 0 to 12, selects cell v+1. The select is bit v of that master's 13-bit select vector. The offset output is address bits 13:0. Both appear on the clock edge after the request.
- R3: A valid request that maps to no cell raises that master's error output for one cycle with an all-zero select. This covers bits 17:14 equal to 13, 14 or 15 inside the region, an address outside both the region and the zero window, and the zero window while no remap is active.
- R4: Trace buffer cells 11, 12 and 13 belong to masters 0, 1 and 2. Master 0 may open all three. Masters 1 and 2 get an error for any trace cell except their own.
- R5: Master 0 may open every cell, 1 to 13.
- R6: Master 1 may open only cells 8, 9, 10 and 12. Master 2 may open only cells 1 to 8 and 13. Any other cell gives an error.
- R7: Remap value 01 maps the zero window (address bits above 13 all zero) to cell 1. Value 10 maps it to cell 3. Values 00 and 11 leave the window unmapped. A remapped access still obeys the master's permissions.
- R8: A remap write is captured on the clock edge where the write enable is high. A request sampled on that same edge still decodes with the previous remap value. Later requests use the new value.
- R9: The bridge-path output is high together with the select when master 0 opens cell 9 or 10, or when master 1 opens cell 8. It is low for every other access.
- R10: With valid low, a master's select, offset, error and bridge outputs are all zero on the next cycle.
- R11: Masters decode independently. Simultaneous requests from all three give each master its own result in the same cycle.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| remap_we | input | 1 | Remap register write enable |
| remap_wdata | input | 2 | Remap value: 00 none, 01 cell 1, 10 cell 3, 11 none |
| m_valid | input | 3 | Request valid, one bit per master |
| m_addr | input | 3 x ADDR_W | Request address per master |
| cell_sel | output | 3 x 13 | One-hot cell select per master, bit v = cell v+1 |
| cell_off | output | 3 x 14 | Offset inside the selected cell per master |
| acc_err | output | 3 | Access error pulse per master |
| bridge_path | output | 3 | Access crosses the slow-domain bridge |

## Verification
The hardest case to reach is the interaction between the remap register and the permission table. The zero window aliases different cells depending on a value that was written earlier, and the same aliased cell is open to one master and closed to another. The stimulus reaches this by reprogramming the remap register before each table entry. It also issues a write and a zero-window access on the same edge, which shows that the old value still governs that access and the new value governs the next one. A reset between a write and an access confirms that the alias is cleared.

// File: rtl/ram_cell_pkg.sv
package ram_cell_pkg;

    localparam int NUM_MASTERS = 3;
    localparam int NUM_CELLS   = 13;
    localparam int CELL_OFF_W  = 14;
    localparam int CELL_IDX_W  = $clog2(NUM_CELLS);

    localparam int MST_SYS   = 0;
    localparam int MST_RADIO = 1;
    localparam int MST_APP   = 2;

    typedef enum logic [1:0] {
        REMAP_NONE  = 2'b00,
        REMAP_CELL1 = 2'b01,
        REMAP_CELL3 = 2'b10,
        REMAP_RSVD  = 2'b11
    } remap_e;

    typedef struct packed {
        logic [NUM_CELLS-1:0]  sel;
        logic [CELL_OFF_W-1:0] off;
        logic                  err;
        logic                  bridge;
    } dec_res_t;

    // idx is zero-based: idx 0 is cell 1, idx 12 is cell 13
    function automatic logic cell_permitted(input int mst, input logic [CELL_IDX_W-1:0] idx);
        logic ok;
        ok = 1'b0;
        case (mst)
            MST_SYS:   ok = (idx < CELL_IDX_W'(NUM_CELLS));
            MST_RADIO: ok = (idx >= 4'd7 && idx <= 4'd9) || (idx == 4'd11);
            MST_APP:   ok = (idx <= 4'd7) || (idx == 4'd12);
            default:   ok = 1'b0;
        endcase
        return ok;
    endfunction

    function automatic logic cell_bridged(input int mst, input logic [CELL_IDX_W-1:0] idx);
        logic br;
        br = 1'b0;
        case (mst)
            MST_SYS:   br = (idx == 4'd8) || (idx == 4'd9);
            MST_RADIO: br = (idx == 4'd7);
            default:   br = 1'b0;
        endcase
        return br;
    endfunction

endpackage

// File: rtl/remap_ctrl.sv
module remap_ctrl
    import ram_cell_pkg::*;
(
    input  logic       clk,
    input  logic       rst,
    input  logic       we,
    input  logic [1:0] wdata,
    output remap_e     mode
);
    logic [1:0] mode_q;

    always_ff @(posedge clk) begin
        if (rst)
            mode_q <= 2'b00;
        else if (we)
            mode_q <= wdata;
    end

    assign mode = remap_e'(mode_q);
endmodule

// File: rtl/cell_addr_decoder.sv
module cell_addr_decoder
    import ram_cell_pkg::*;
#(
    parameter int              MASTER_ID   = 0,
    parameter int              ADDR_W      = 32,
    parameter logic [ADDR_W-1:0] REGION_BASE = 32'h2000_0000
) (
    input  logic              valid,
    input  logic [ADDR_W-1:0] addr,
    input  remap_e            mode,
    output dec_res_t          res
);
    localparam int HI_LSB = CELL_OFF_W + CELL_IDX_W;

    logic [CELL_IDX_W-1:0] field;
    logic [CELL_IDX_W-1:0] idx;
    logic                  in_region;
    logic                  in_zero;
    logic                  hit;
    logic                  allowed;

    assign field     = addr[CELL_OFF_W +: CELL_IDX_W];
    assign in_region = (addr[ADDR_W-1:HI_LSB] == REGION_BASE[ADDR_W-1:HI_LSB]);
    assign in_zero   = (addr[ADDR_W-1:CELL_OFF_W] == '0);

    always_comb begin
        hit = 1'b0;
        idx = '0;
        if (in_region && field < CELL_IDX_W'(NUM_CELLS)) begin
            hit = 1'b1;
            idx = field;
        end else if (in_zero && mode == REMAP_CELL1) begin
            hit = 1'b1;
            idx = CELL_IDX_W'(0);
        end else if (in_zero && mode == REMAP_CELL3) begin
            hit = 1'b1;
            idx = CELL_IDX_W'(2);
        end
    end

    assign allowed = valid && hit && cell_permitted(MASTER_ID, idx);

    always_comb begin
        res        = '0;
        res.err    = valid && !allowed;
        if (allowed) begin
            res.sel    = NUM_CELLS'(1) << idx;
            res.off    = addr[CELL_OFF_W-1:0];
            res.bridge = cell_bridged(MASTER_ID, idx);
        end
    end
endmodule

// File: rtl/decode_out_stage.sv
module decode_out_stage
    import ram_cell_pkg::*;
(
    input  logic     clk,
    input  logic     rst,
    input  dec_res_t d,
    output dec_res_t q
);
    always_ff @(posedge clk) begin
        if (rst)
            q <= '0;
        else
            q <= d;
    end
endmodule

// File: rtl/ram_cell_decoder.sv
module ram_cell_decoder
    import ram_cell_pkg::*;
#(
    parameter int                ADDR_W      = 32,
    parameter logic [ADDR_W-1:0] REGION_BASE = 32'h2000_0000
) (
    input  logic                                    clk,
    input  logic                                    rst,
    input  logic                                    remap_we,
    input  logic [1:0]                              remap_wdata,
    input  logic [NUM_MASTERS-1:0]                  m_valid,
    input  logic [NUM_MASTERS-1:0][ADDR_W-1:0]      m_addr,
    output logic [NUM_MASTERS-1:0][NUM_CELLS-1:0]   cell_sel,
    output logic [NUM_MASTERS-1:0][CELL_OFF_W-1:0]  cell_off,
    output logic [NUM_MASTERS-1:0]                  acc_err,
    output logic [NUM_MASTERS-1:0]                  bridge_path
);
    remap_e mode;

    remap_ctrl u_remap (
        .clk   (clk),
        .rst   (rst),
        .we    (remap_we),
        .wdata (remap_wdata),
        .mode  (mode)
    );

    for (genvar g = 0; g < NUM_MASTERS; g++) begin : g_master
        dec_res_t comb_res;
        dec_res_t reg_res;

        cell_addr_decoder #(
            .MASTER_ID   (g),
            .ADDR_W      (ADDR_W),
            .REGION_BASE (REGION_BASE)
        ) u_dec (
            .valid (m_valid[g]),
            .addr  (m_addr[g]),
            .mode  (mode),
            .res   (comb_res)
        );

        decode_out_stage u_stage (
            .clk (clk),
            .rst (rst),
            .d   (comb_res),
            .q   (reg_res)
        );

        assign cell_sel[g]    = reg_res.sel;
        assign cell_off[g]    = reg_res.off;
        assign acc_err[g]     = reg_res.err;
        assign bridge_path[g] = reg_res.bridge;
    end
endmodule

// File: rtl/ram_cell_decoder_checker.sv
module ram_cell_decoder_checker
    import ram_cell_pkg::*;
(
    input logic                                   clk,
    input logic                                   rst,
    input logic [NUM_MASTERS-1:0]                 m_valid,
    input logic [NUM_MASTERS-1:0][NUM_CELLS-1:0]  cell_sel,
    input logic [NUM_MASTERS-1:0][CELL_OFF_W-1:0] cell_off,
    input logic [NUM_MASTERS-1:0]                 acc_err,
    input logic [NUM_MASTERS-1:0]                 bridge_path
);
    p_reset_clear_r1: assert property (@(posedge clk)
        rst |=> (cell_sel == '0 && acc_err == '0 && bridge_path == '0 && cell_off == '0));

    for (genvar g = 0; g < NUM_MASTERS; g++) begin : g_chk
        p_sel_onehot_r2: assert property (@(posedge clk) disable iff (rst)
            $onehot0(cell_sel[g]));

        p_err_no_sel_r3: assert property (@(posedge clk) disable iff (rst)
            acc_err[g] |-> (cell_sel[g] == '0 && cell_off[g] == '0));

        p_bridge_with_sel_r9: assert property (@(posedge clk) disable iff (rst)
            bridge_path[g] |-> (cell_sel[g] != '0));

        p_idle_quiet_r10: assert property (@(posedge clk) disable iff (rst)
            !m_valid[g] |=> (cell_sel[g] == '0 && !acc_err[g]));

        p_valid_has_result_r10: assert property (@(posedge clk) disable iff (rst)
            m_valid[g] |=> ((cell_sel[g] != '0) != acc_err[g]));
    end

    p_radio_trace_r4: assert property (@(posedge clk) disable iff (rst)
        !cell_sel[MST_RADIO][10] && !cell_sel[MST_RADIO][12]);

    p_app_trace_r4: assert property (@(posedge clk) disable iff (rst)
        !cell_sel[MST_APP][10] && !cell_sel[MST_APP][11]);

    p_radio_bridge_cell_r9: assert property (@(posedge clk) disable iff (rst)
        bridge_path[MST_RADIO] |-> cell_sel[MST_RADIO][7]);

    p_app_no_bridge_r9: assert property (@(posedge clk) disable iff (rst)
        !bridge_path[MST_APP]);
endmodule

bind ram_cell_decoder ram_cell_decoder_checker u_checker (
    .clk         (clk),
    .rst         (rst),
    .m_valid     (m_valid),
    .cell_sel    (cell_sel),
    .cell_off    (cell_off),
    .acc_err     (acc_err),
    .bridge_path (bridge_path)
);

// File: tb/ram_cell_decoder_test.sv
module ram_cell_decoder_test;
    import ram_cell_pkg::*;

    localparam int AW = 32;

    logic                                   clk = 1'b0;
    logic                                   rst = 1'b1;
    logic                                   remap_we = 1'b0;
    logic [1:0]                             remap_wdata = 2'b00;
    logic [NUM_MASTERS-1:0]                 m_valid = '0;
    logic [NUM_MASTERS-1:0][AW-1:0]         m_addr = '0;
    logic [NUM_MASTERS-1:0][NUM_CELLS-1:0]  cell_sel;
    logic [NUM_MASTERS-1:0][CELL_OFF_W-1:0] cell_off;
    logic [NUM_MASTERS-1:0]                 acc_err;
    logic [NUM_MASTERS-1:0]                 bridge_path;

    int checks = 0;
    int errors = 0;
    bit done = 1'b0;

    always #10 clk = ~clk;

    ram_cell_decoder #(.ADDR_W(AW), .REGION_BASE(32'h2000_0000)) uut (
        .clk         (clk),
        .rst         (rst),
        .remap_we    (remap_we),
        .remap_wdata (remap_wdata),
        .m_valid     (m_valid),
        .m_addr      (m_addr),
        .cell_sel    (cell_sel),
        .cell_off    (cell_off),
        .acc_err     (acc_err),
        .bridge_path (bridge_path)
    );

    // {remap, master, addr, expected cell (0 = none), expected err, expected bridge}
    localparam int NV = 27;
    localparam logic [41:0] VECS [NV] = '{
        {2'd0, 2'd0, 32'h2000_0123, 4'd1,  1'b0, 1'b0},  // R2 R5
        {2'd0, 2'd0, 32'h2002_3FFF, 4'd9,  1'b0, 1'b1},  // R9
        {2'd0, 2'd0, 32'h2002_7000, 4'd10, 1'b0, 1'b1},  // R9
        {2'd0, 2'd0, 32'h2002_8010, 4'd11, 1'b0, 1'b0},  // R4
        {2'd0, 2'd0, 32'h2002_C000, 4'd12, 1'b0, 1'b0},  // R4
        {2'd0, 2'd0, 32'h2003_0004, 4'd13, 1'b0, 1'b0},  // R4
        {2'd0, 2'd1, 32'h2001_C008, 4'd8,  1'b0, 1'b1},  // R6 R9
        {2'd0, 2'd1, 32'h2002_0000, 4'd9,  1'b0, 1'b0},  // R6
        {2'd0, 2'd1, 32'h2002_C100, 4'd12, 1'b0, 1'b0},  // R4
        {2'd0, 2'd1, 32'h2002_8000, 4'd0,  1'b1, 1'b0},  // R4
        {2'd0, 2'd1, 32'h2003_0000, 4'd0,  1'b1, 1'b0},  // R4
        {2'd0, 2'd1, 32'h2000_4000, 4'd0,  1'b1, 1'b0},  // R6
        {2'd0, 2'd2, 32'h2001_8000, 4'd7,  1'b0, 1'b0},  // R6
        {2'd0, 2'd2, 32'h2001_C000, 4'd8,  1'b0, 1'b0},  // R6
        {2'd0, 2'd2, 32'h2003_0ABC, 4'd13, 1'b0, 1'b0},  // R4
        {2'd0, 2'd2, 32'h2002_C000, 4'd0,  1'b1, 1'b0},  // R4
        {2'd0, 2'd2, 32'h2002_0000, 4'd0,  1'b1, 1'b0},  // R6
        {2'd0, 2'd0, 32'h2003_4000, 4'd0,  1'b1, 1'b0},  // R3
        {2'd0, 2'd0, 32'h2003_C000, 4'd0,  1'b1, 1'b0},  // R3
        {2'd0, 2'd0, 32'h1000_0000, 4'd0,  1'b1, 1'b0},  // R3
        {2'd1, 2'd0, 32'h0000_0040, 4'd1,  1'b0, 1'b0},  // R7
        {2'd2, 2'd0, 32'h0000_0040, 4'd3,  1'b0, 1'b0},  // R7
        {2'd2, 2'd2, 32'h0000_3FFC, 4'd3,  1'b0, 1'b0},  // R7
        {2'd1, 2'd1, 32'h0000_0000, 4'd0,  1'b1, 1'b0},  // R7
        {2'd0, 2'd0, 32'h0000_0040, 4'd0,  1'b1, 1'b0},  // R3 R7
        {2'd3, 2'd0, 32'h0000_0000, 4'd0,  1'b1, 1'b0},  // R7
        {2'd1, 2'd0, 32'h0000_4000, 4'd0,  1'b1, 1'b0}   // R7
    };

    task automatic check_master(input int m, input int exp_cell, input logic exp_err,
                                input logic exp_br, input logic [CELL_OFF_W-1:0] exp_off,
                                input string req);
        logic [NUM_CELLS-1:0] exp_sel;
        exp_sel = (exp_cell == 0) ? '0 : (NUM_CELLS'(1) << (exp_cell - 1));
        checks++;
        if (cell_sel[m] !== exp_sel || acc_err[m] !== exp_err ||
            bridge_path[m] !== exp_br || cell_off[m] !== exp_off) begin
            errors++;
            $display("FAIL %s master %0d: sel=%h err=%b br=%b off=%h expected sel=%h err=%b br=%b off=%h",
                     req, m, cell_sel[m], acc_err[m], bridge_path[m], cell_off[m],
                     exp_sel, exp_err, exp_br, exp_off);
        end
    endtask

    task automatic write_remap(input logic [1:0] v);
        @(negedge clk);
        remap_we    = 1'b1;
        remap_wdata = v;
        @(negedge clk);
        remap_we    = 1'b0;
    endtask

    // drive at negedge, result registered at next posedge, sampled at the negedge after
    task automatic issue(input int m, input logic [AW-1:0] a);
        m_valid    = '0;
        m_valid[m] = 1'b1;
        m_addr[m]  = a;
        @(negedge clk);
        m_valid = '0;
    endtask

    initial begin
        repeat (3) @(negedge clk);
        m_valid = '1;
        m_addr  = '{32'h2000_0000, 32'h2001_C000, 32'h2000_0000};
        @(negedge clk);
        for (int m = 0; m < NUM_MASTERS; m++) check_master(m, 0, 1'b0, 1'b0, '0, "R1 reset");
        m_valid = '0;
        rst = 1'b0;
        @(negedge clk);
        for (int m = 0; m < NUM_MASTERS; m++) check_master(m, 0, 1'b0, 1'b0, '0, "R10 idle");

        for (int i = 0; i < NV; i++) begin
            int m;
            int ec;
            logic [AW-1:0] a;
            m  = int'(VECS[i][39:38]);
            a  = VECS[i][37:6];
            ec = int'(VECS[i][5:2]);
            write_remap(VECS[i][41:40]);
            issue(m, a);
            check_master(m, ec, VECS[i][1], VECS[i][0],
                         VECS[i][1] ? '0 : a[CELL_OFF_W-1:0], "R2 R3 R4 R5 R6 R7 R9 table");
            for (int o = 0; o < NUM_MASTERS; o++)
                if (o != m) check_master(o, 0, 1'b0, 1'b0, '0, "R10 other masters idle");
        end

        // R3: error is a single pulse
        write_remap(2'd0);
        issue(1, 32'h2000_0000);
        check_master(1, 0, 1'b1, 1'b0, '0, "R3 error pulse");
        @(negedge clk);
        check_master(1, 0, 1'b0, 1'b0, '0, "R3 error clears");

        // R11: all masters at once
        m_valid = '1;
        m_addr[0] = 32'h2002_4010;
        m_addr[1] = 32'h2001_C020;
        m_addr[2] = 32'h2002_8000;
        @(negedge clk);
        m_valid = '0;
        check_master(0, 10, 1'b0, 1'b1, 14'h0010, "R11 sys");
        check_master(1, 8,  1'b0, 1'b1, 14'h0020, "R11 radio");
        check_master(2, 0,  1'b1, 1'b0, '0,       "R11 app");

        // R8: write and access on the same edge
        write_remap(2'd0);
        remap_we    = 1'b1;
        remap_wdata = 2'd1;
        m_valid[0]  = 1'b1;
        m_addr[0]   = 32'h0000_0100;
        @(negedge clk);
        remap_we = 1'b0;
        check_master(0, 0, 1'b1, 1'b0, '0, "R8 old remap on write edge");
        @(negedge clk);
        m_valid = '0;
        check_master(0, 1, 1'b0, 1'b0, 14'h0100, "R8 new remap next access");

        // R1: reset clears remap
        write_remap(2'd2);
        rst = 1'b1;
        @(negedge clk);
        rst = 1'b0;
        issue(0, 32'h0000_0000);
        check_master(0, 0, 1'b1, 1'b0, '0, "R1 remap cleared by reset");

        done = 1'b1;
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin
        repeat (100000) @(posedge clk);
        if (!done) begin
            checks++;
            errors++;
            $display("FAIL watchdog: run did not complete, actual hung expected done");
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end
endmodule